// File: doc/BRIEF.md
# Out-of-Limit Monitor with Sticky Interrupt Status

This block watches a stream of measurement results. A value source hands it one result at a time, tagged with a channel index and a valid strobe, and the sources visit the channels in a repeating order. Each result is stored in a per-channel value register. It is then checked against a programmable upper and lower bound for that channel. A result outside its bounds sets a sticky bit for that channel, held in one of two 8-bit status registers.

An active-low interrupt line is driven low while any status bit that is not masked is set. A global enable bit in the configuration register must also be set, and that bit is clear after reset. Software uses a simple register port to program the bounds, the masks and the configuration, and to read back values and status. A read of a status register at its normal address returns the contents and then empties it. A read at its mirror address returns the same contents and leaves them in place.

Top module: `lim_monitor`

## Requirements
- R1: After reset, all upper bounds read 0xFF, all lower bounds read 0x00, both status registers, both mask registers and the configuration register (0x40) read 0x00, and irq_n_o is high.
- R2: A strobed result for channel c is stored and reads back at address 0x20+c. Writes to 0x20..0x2F do not change these registers. Addresses outside the map read as 0x00.
- R3: A result greater than the upper bound of its channel (0x00+c), or less than its lower bound (0x10+c), sets the status bit of that channel. A result equal to either bound sets nothing.
- R4: A set status bit stays set through later in-bound results and is cleared only by a clearing read.
- R5: Channel c maps to bit c of status register 0x41 for c < 8, and to bit c-8 of status register 0x42 otherwise.
- R6: A read of 0x41 or 0x42 returns that register's value from before the read, on rd_data_o one clock edge after the request, and clears the whole register.
- R7: Reads of the mirror addresses 0x4C (same contents as 0x41) and 0x4D (same contents as 0x42) return the same data and clear nothing.
- R8: Mask registers 0x43 and 0x44 use the same bit positions as the status registers. A set mask bit keeps its status bit from pulling irq_n_o low, but the status bit is still recorded.
- R9: irq_n_o is low only while bit 1 of 0x40 is set and at least one unmasked status bit is set.
- R10: When a violation arrives in the same cycle as a clearing read of the register that holds its bit, the new bit survives the clear.
- R11: A strobed result whose channel index is NUM_CH or higher changes no status bit and no value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_valid_i | input | 1 | Result strobe |
| samp_ch_i | input | CH_W | Channel index of the result |
| samp_val_i | input | 8 | Result value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, registered |
| irq_n_o | output | 1 | Interrupt, active low (low = pull the open-drain line) |

## Verification
A strobed result updates the value and status registers at the clock edge that samples the strobe. irq_n_o follows the status, mask and enable registers combinationally, so it settles right after that edge and right after an edge that writes a mask or the enable bit. Read data appears at the edge after the read request. The bench therefore drives every strobe on the falling edge and samples the outputs on the following falling edge. When a clearing read and a new violation arrive in the same cycle, the bench checks both the returned pre-clear data and the surviving bit with a later mirror read.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 2 * DATA_W;

  localparam logic [7:0] A_HI_BASE  = 8'h00;
  localparam logic [7:0] A_LO_BASE  = 8'h10;
  localparam logic [7:0] A_VAL_BASE = 8'h20;
  localparam logic [7:0] A_CFG      = 8'h40;
  localparam logic [7:0] A_STAT_A   = 8'h41;
  localparam logic [7:0] A_STAT_B   = 8'h42;
  localparam logic [7:0] A_MASK_A   = 8'h43;
  localparam logic [7:0] A_MASK_B   = 8'h44;
  localparam logic [7:0] A_MIR_A    = 8'h4C;
  localparam logic [7:0] A_MIR_B    = 8'h4D;

  localparam int CFG_IRQ_EN_BIT = 1;

  typedef enum logic [1:0] {
    RK_PLAIN = 2'd0,
    RK_CLR_A = 2'd1,
    RK_CLR_B = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/lim_regfile.sv
module lim_regfile
  import lim_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              samp_valid_i,
  input  logic [CH_W-1:0]   samp_ch_i,
  input  logic [DATA_W-1:0] samp_val_i,
  output logic [DATA_W-1:0] hi_o   [NUM_CH],
  output logic [DATA_W-1:0] lo_o   [NUM_CH],
  output logic [DATA_W-1:0] val_o  [NUM_CH],
  output logic [STAT_W-1:0] mask_o,
  output logic [DATA_W-1:0] cfg_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_o[i] <= '1;
        lo_o[i] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == A_HI_BASE + 8'(i)) hi_o[i] <= wr_data_i;
        if (wr_addr_i == A_LO_BASE + 8'(i)) lo_o[i] <= wr_data_i;
      end
    end

    // value registers have no write path from the register port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_o[i] <= '0;
      else if (samp_valid_i && samp_ch_i == CH_W'(i)) val_o[i] <= samp_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      cfg_o  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MASK_A: mask_o[DATA_W-1:0]      <= wr_data_i;
        A_MASK_B: mask_o[STAT_W-1:DATA_W] <= wr_data_i;
        A_CFG:    cfg_o                   <= wr_data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lim_cmp.sv
module lim_cmp
  import lim_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              samp_valid_i,
  input  logic [CH_W-1:0]   samp_ch_i,
  input  logic [DATA_W-1:0] samp_val_i,
  input  logic [DATA_W-1:0] hi_i [NUM_CH],
  input  logic [DATA_W-1:0] lo_i [NUM_CH],
  output logic [STAT_W-1:0] set_o
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i < NUM_CH) begin : g_live
      assign set_o[i] = samp_valid_i && (samp_ch_i == CH_W'(i)) &&
                        ((samp_val_i > hi_i[i]) || (samp_val_i < lo_i[i]));
    end else begin : g_tie
      assign set_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/lim_status.sv
module lim_status
  import lim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  rd_kind_e          rd_kind_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              irq_en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_n_o
);
  logic [STAT_W-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    case (rd_kind_i)
      RK_CLR_A: clr_vec[DATA_W-1:0]      = '1;
      RK_CLR_B: clr_vec[STAT_W-1:DATA_W] = '1;
      default: ;
    endcase
  end

  // a fresh violation outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_vec) | set_i;
  end

  assign irq_n_o = ~(irq_en_i & (|(stat_o & ~mask_i)));
endmodule

// File: rtl/lim_monitor.sv
module lim_monitor
  import lim_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_valid_i,
  input  logic [CH_W-1:0]   samp_ch_i,
  input  logic [DATA_W-1:0] samp_val_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [7:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  logic [DATA_W-1:0] hi_q  [NUM_CH];
  logic [DATA_W-1:0] lo_q  [NUM_CH];
  logic [DATA_W-1:0] val_q [NUM_CH];
  logic [STAT_W-1:0] mask_q;
  logic [DATA_W-1:0] cfg_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_q;
  logic              irq_en;
  rd_kind_e          rd_kind;
  logic [DATA_W-1:0] rd_mux;

  assign irq_en = cfg_q[CFG_IRQ_EN_BIT];

  lim_regfile #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .samp_valid_i (samp_valid_i),
    .samp_ch_i    (samp_ch_i),
    .samp_val_i   (samp_val_i),
    .hi_o         (hi_q),
    .lo_o         (lo_q),
    .val_o        (val_q),
    .mask_o       (mask_q),
    .cfg_o        (cfg_q)
  );

  lim_cmp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cmp (
    .samp_valid_i (samp_valid_i),
    .samp_ch_i    (samp_ch_i),
    .samp_val_i   (samp_val_i),
    .hi_i         (hi_q),
    .lo_i         (lo_q),
    .set_o        (set_vec)
  );

  always_comb begin
    rd_kind = RK_PLAIN;
    if (rd_en_i && rd_addr_i == A_STAT_A) rd_kind = RK_CLR_A;
    if (rd_en_i && rd_addr_i == A_STAT_B) rd_kind = RK_CLR_B;
  end

  lim_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .rd_kind_i (rd_kind),
    .mask_i    (mask_q),
    .irq_en_i  (irq_en),
    .stat_o    (stat_q),
    .irq_n_o   (irq_n_o)
  );

  always_comb begin
    case (rd_addr_i)
      A_CFG:             rd_mux = cfg_q;
      A_STAT_A, A_MIR_A: rd_mux = stat_q[DATA_W-1:0];
      A_STAT_B, A_MIR_B: rd_mux = stat_q[STAT_W-1:DATA_W];
      A_MASK_A:          rd_mux = mask_q[DATA_W-1:0];
      A_MASK_B:          rd_mux = mask_q[STAT_W-1:DATA_W];
      default:           rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr_i == A_HI_BASE  + 8'(i)) rd_mux = hi_q[i];
      if (rd_addr_i == A_LO_BASE  + 8'(i)) rd_mux = lo_q[i];
      if (rd_addr_i == A_VAL_BASE + 8'(i)) rd_mux = val_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/lim_monitor_chk.sv
module lim_monitor_chk
  import lim_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              samp_valid_i,
  input logic [CH_W-1:0]   samp_ch_i,
  input logic              rd_en_i,
  input logic [7:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_n_o,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq_en
);
  localparam logic [CH_W:0] CH_LIM = (CH_W+1)'(NUM_CH);

  AST_STICKY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(stat_q) & ~stat_q) & 16'h00FF) != 16'h0) |-> $past(rd_en_i && rd_addr_i == A_STAT_A)); // R4
  AST_STICKY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(stat_q) & ~stat_q) & 16'hFF00) != 16'h0) |-> $past(rd_en_i && rd_addr_i == A_STAT_B)); // R4
  AST_ONE_NEW_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stat_q & ~$past(stat_q)) <= 1); // R5
  AST_RD_PRECLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_STAT_A) |=> rd_data_o == $past(stat_q[7:0])); // R6
  AST_MIRROR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (rd_addr_i == A_MIR_A || rd_addr_i == A_MIR_B)) |=> (($past(stat_q) & ~stat_q) == 16'h0)); // R7
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~mask_q) == 16'h0) |-> irq_n_o); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> irq_n_o); // R9
  AST_BAD_CH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_valid_i && {1'b0, samp_ch_i} >= CH_LIM && !rd_en_i) |=> stat_q == $past(stat_q)); // R11
endmodule

bind lim_monitor lim_monitor_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .samp_valid_i (samp_valid_i),
  .samp_ch_i    (samp_ch_i),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .irq_n_o      (irq_n_o),
  .stat_q       (stat_q),
  .mask_q       (mask_q),
  .irq_en       (irq_en)
);

// File: tb/lim_monitor_bench.sv
module lim_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 12;
  localparam int CH_W = 4;
  localparam int NVEC = 10;
  // {channel[12:9], value[8:1], violation[0]}; bounds are 0x40..0xC0
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd0,  8'h80, 1'b0}, {4'd0,  8'hC0, 1'b0}, {4'd0,  8'hC1, 1'b1},
    {4'd1,  8'h40, 1'b0}, {4'd1,  8'h3F, 1'b1}, {4'd7,  8'hFF, 1'b1},
    {4'd8,  8'h00, 1'b1}, {4'd11, 8'h41, 1'b0}, {4'd9,  8'hBF, 1'b0},
    {4'd10, 8'hC1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_valid = 1'b0;
  logic [CH_W-1:0] samp_ch = '0;
  logic [7:0] samp_val = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic irq_n;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lim_monitor #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_lim_monitor (
    .clk_i(clk), .rst_ni(rst_n), .samp_valid_i(samp_valid), .samp_ch_i(samp_ch),
    .samp_val_i(samp_val), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_sample(input logic [CH_W-1:0] c, input logic [7:0] v);
    @(negedge clk); samp_valid = 1'b1; samp_ch = c; samp_val = v;
    @(negedge clk); samp_valid = 1'b0;
  endtask

  task automatic read_mirrors(output logic [15:0] s);
    logic [7:0] lo, hi;
    do_read(8'h4C, lo);
    do_read(8'h4D, hi);
    s = {hi, lo};
  endtask

  task automatic clear_all();
    logic [7:0] d;
    do_read(8'h41, d);
    do_read(8'h42, d);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL WDOG: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 16'(irq_n), 16'h1);
    do_read(8'h40, d); chk("R1 R9 cfg", 16'(d), 16'h00);
    do_read(8'h00, d); chk("R1 hi0", 16'(d), 16'hFF);
    do_read(8'h1B, d); chk("R1 lo11", 16'(d), 16'h00);
    do_read(8'h43, d); chk("R1 mask", 16'(d), 16'h00);
    read_mirrors(s);   chk("R1 status", s, 16'h0000);
    do_read(8'h7F, d); chk("R2 unmapped", 16'(d), 16'h00);

    for (int i = 0; i < NUM_CH; i++) begin
      do_write(8'h00 + 8'(i), 8'hC0);
      do_write(8'h10 + 8'(i), 8'h40);
    end

    // R3 R5 R2 vector table
    for (int k = 0; k < NVEC; k++) begin
      logic [CH_W-1:0] c;
      logic [7:0] v;
      c = VEC[k][12:9];
      v = VEC[k][8:1];
      clear_all();
      do_sample(c, v);
      read_mirrors(s);
      chk("R3 R5 status", s, VEC[k][0] ? (16'h1 << c) : 16'h0);
      do_read(8'h20 + 8'(c), d);
      chk("R2 value", 16'(d), 16'(v));
    end

    do_write(8'h20, 8'h55);
    do_read(8'h20, d); chk("R2 write ignored", 16'(d), 16'hC1);

    // R4 sticky, R6 clear, R7 mirror keeps
    clear_all();
    do_sample(4'd2, 8'hF0);
    do_sample(4'd2, 8'h80);
    read_mirrors(s);   chk("R4 sticky", s, 16'h0004);
    do_read(8'h41, d); chk("R7 R6 pre-clear", 16'(d), 16'h04);
    do_read(8'h41, d); chk("R6 cleared", 16'(d), 16'h00);

    // R9 enable, R8 masks
    do_sample(4'd3, 8'h00);
    chk("R9 disabled", 16'(irq_n), 16'h1);
    do_write(8'h40, 8'h02);
    chk("R9 enabled", 16'(irq_n), 16'h0);
    do_write(8'h43, 8'h08);
    chk("R8 masked", 16'(irq_n), 16'h1);
    read_mirrors(s);   chk("R8 still set", s, 16'h0008);
    do_sample(4'd9, 8'hFF);
    chk("R8 unmasked high", 16'(irq_n), 16'h0);
    do_write(8'h44, 8'h02);
    chk("R8 masked high", 16'(irq_n), 16'h1);
    do_write(8'h43, 8'h00);
    do_write(8'h44, 8'h00);
    chk("R8 unmask", 16'(irq_n), 16'h0);
    clear_all();
    chk("R9 no status", 16'(irq_n), 16'h1);

    // R10 set and clear together
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h41;
    samp_valid = 1'b1; samp_ch = 4'd5; samp_val = 8'hFF;
    @(negedge clk);
    rd_en = 1'b0; samp_valid = 1'b0;
    chk("R10 read data", 16'(rd_data), 16'h00);
    read_mirrors(s);   chk("R10 survives", s, 16'h0020);
    chk("R10 irq", 16'(irq_n), 16'h0);
    clear_all();

    // R11 out-of-range channel
    do_sample(4'd12, 8'h00);
    do_sample(4'd15, 8'hFF);
    read_mirrors(s);   chk("R11 status", s, 16'h0000);
    chk("R11 irq", 16'(irq_n), 16'h1);
    do_read(8'h2C, d); chk("R11 value", 16'(d), 16'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule